// File: doc/BRIEF.md
# Pin/Register Control Mode Selector

This block resolves the control settings of an audio converter: the de-emphasis select, the double-speed select, the interface-format select and the master-clock ratio select. A mode pin picks between two control schemes. With the mode pin high (parallel control), the settings come straight from strap pins. With the mode pin low (serial control), the two clock-ratio strap pins and the format strap pin are reused as the serial clock, serial data and active-low chip-select of a small write-only register bank. The format and clock-ratio settings then come from that bank, and the de-emphasis and speed pins are ORed with their register bits.

The serial lines are brought into the system clock domain through a two-stage synchronizer and oversampled. A frame is committed only when chip-select rises after exactly sixteen bits. Whenever double speed is in effect, de-emphasis is forced to its off code.

Top module: `ctl_mode_sel`

## Requirements
- R1: With `mode_par_i`=1, `dem_sel_o`, `speed_sel_o`, `fmt_sel_o` and `mclk_sel_o` follow `dem_pin_i`, `speed_pin_i`, `fmt_pin_i` and `clksel_pin_i` directly (subject to R5).
- R2: With `mode_par_i`=0, `fmt_sel_o` is bit 0 and `mclk_sel_o` is bits [2:1] of register 0, whatever the strap pins carry.
- R3: With `mode_par_i`=0, the effective de-emphasis is `dem_pin_i` OR register 1 bits [1:0`]`, and the effective speed is `speed_pin_i` OR register 1 bit 2.
- R4: When the speed is normal, the de-emphasis code passes to `dem_sel_o` unchanged: 00 = 44.1 kHz, 01 = off, 10 = 48 kHz, 11 = 32 kHz.
- R5: Whenever `speed_sel_o`=1, `dem_sel_o` is 01 (off).
- R6: Reset loads register 0 with 0x00 and register 1 with 0x01, so serial mode with all pins low gives de-emphasis 01, speed 0, format 0 and clock ratio 00.
- R7: A serial frame is 16 bits, sent MSB first on rising edges of `clksel_pin_i[0]`, with data on `clksel_pin_i[1]` and `fmt_pin_i` low: bits [15:13] address, bit 12 write flag (1 = write), bits [11:8] unused, bits [7:0] data. It is committed when `fmt_pin_i` rises.
- R8: A frame with fewer or more than 16 clock edges changes no register.
- R9: A frame with write flag 0 or with an address other than 0 or 1 changes no register.
- R10: While `mode_par_i`=1, activity on the strap pins writes no register.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_par_i | input | 1 | 1 = parallel (pin) control, 0 = serial (register) control |
| clksel_pin_i | input | 2 | Clock-ratio straps; in serial mode [0] is serial clock, [1] serial data |
| fmt_pin_i | input | 1 | Format strap; in serial mode active-low chip-select |
| dem_pin_i | input | 2 | De-emphasis strap pins |
| speed_pin_i | input | 1 | Double-speed strap pin |
| dem_sel_o | output | 2 | Resolved de-emphasis code |
| speed_sel_o | output | 1 | Resolved double-speed select |
| fmt_sel_o | output | 1 | Resolved interface-format select |
| mclk_sel_o | output | 2 | Resolved master-clock ratio select |

## Verification
Pin-driven results are combinational, so the bench samples them on the falling clock edge after the pins change. A register write reaches the outputs about four clock edges after chip-select rises: two synchronizer stages, the edge detector, then the commit register. The bench drives each serial phase for four clocks and waits eight clocks after chip-select rises before it samples. Rejected frames are checked the same way: the bench samples the outputs after the same wait and expects the earlier values.

// File: rtl/ctl_mode_pkg.sv
package ctl_mode_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int FRAME_W  = 16;
  localparam int NUM_REGS = 2;
  localparam logic [1:0] DEM_OFF = 2'b01;

  // reset value of register idx: register 1 holds de-emphasis off
  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    return (idx == 1) ? DATA_W'(DEM_OFF) : '0;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx #(
  parameter int FRAME_W = 16,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              csn_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
  localparam int WFLAG = FRAME_W - ADDR_W - 1;

  logic               sclk_q, csn_q;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               wr_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [DATA_W-1:0]  data_d;
  logic               sclk_rise, cs_rise, cs_fall, shift_en;

  always_comb begin
    sclk_rise = sclk_i & ~sclk_q;
    cs_rise   = csn_i & ~csn_q;
    cs_fall   = ~csn_i & csn_q;
    shift_en  = ~csn_i & sclk_rise;

    cnt_d = cnt_q;
    if (cs_fall)                           cnt_d = '0;
    else if (shift_en && cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;

    shift_d = shift_en ? {shift_q[FRAME_W-2:0], sdata_i} : shift_q;

    wr_d   = cs_rise && (cnt_q == CNT_FULL) && shift_q[WFLAG];
    addr_d = shift_q[FRAME_W-1 -: ADDR_W];
    data_d = shift_q[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
      wr_o    <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      sclk_q  <= sclk_i;
      csn_q   <= csn_i;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      wr_o    <= wr_d;
      if (wr_d) begin
        addr_o <= addr_d;
        data_o <= data_d;
      end
    end
  end

  // R8: bit counter saturates just past a full frame
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVER);
  // R8: one commit per chip-select release
  p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !wr_o);
  // R7: a commit follows chip-select being high
  p_wr_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> $past(csn_i));
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_mode_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         data_i,
  output logic [NR-1:0][DW-1:0] regs_o
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic en;
    assign en = wr_i && (addr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_o[g] <= reg_default(g);
      else if (en) regs_o[g] <= data_i;
    end
  end

  // R9: a write to an unmapped address leaves every register alone
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i >= AW'(NR)) |=> $stable(regs_o));
  // R9: no write strobe, no change
  p_no_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(regs_o));
endmodule

// File: rtl/ctl_mode_sel.sv
module ctl_mode_sel
  import ctl_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_par_i,
  input  logic [1:0] clksel_pin_i,
  input  logic       fmt_pin_i,
  input  logic [1:0] dem_pin_i,
  input  logic       speed_pin_i,
  output logic [1:0] dem_sel_o,
  output logic       speed_sel_o,
  output logic       fmt_sel_o,
  output logic [1:0] mclk_sel_o
);
  logic                          csn_raw;
  logic [2:0]                    ser_s;
  logic                          wr;
  logic [ADDR_W-1:0]             wr_addr;
  logic [DATA_W-1:0]             wr_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [1:0]                    dem_eff;
  logic                          unused_bits;

  // serial lines only exist in serial mode; chip-select idles high otherwise
  assign csn_raw = mode_par_i | fmt_pin_i;

  ctl_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({csn_raw, clksel_pin_i[1], clksel_pin_i[0]}),
    .q_o  (ser_s)
  );

  ctl_serial_rx #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (ser_s[0]),
    .sdata_i(ser_s[1]),
    .csn_i  (ser_s[2]),
    .wr_o   (wr),
    .addr_o (wr_addr),
    .data_o (wr_data)
  );

  ctl_reg_bank u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (wr),
    .addr_i(wr_addr),
    .data_i(wr_data),
    .regs_o(regs)
  );

  assign unused_bits = ^{regs[0][DATA_W-1:3], regs[1][DATA_W-1:3]};

  always_comb begin
    if (mode_par_i) begin
      dem_eff     = dem_pin_i;
      speed_sel_o = speed_pin_i;
      fmt_sel_o   = fmt_pin_i;
      mclk_sel_o  = clksel_pin_i;
    end else begin
      dem_eff     = dem_pin_i | regs[1][1:0];
      speed_sel_o = speed_pin_i | regs[1][2];
      fmt_sel_o   = regs[0][0];
      mclk_sel_o  = regs[0][2:1];
    end
    dem_sel_o = speed_sel_o ? DEM_OFF : dem_eff;
  end

  // R5: double speed always reports de-emphasis off
  p_dspeed_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    speed_sel_o |-> dem_sel_o == DEM_OFF);
  // R1: parallel mode passes the pins
  p_par_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_par_i && !speed_pin_i) |-> (dem_sel_o == dem_pin_i && fmt_sel_o == fmt_pin_i
                                      && mclk_sel_o == clksel_pin_i));
  // R3: in serial mode the speed pin still forces double speed
  p_ser_pin_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_par_i && speed_pin_i) |-> speed_sel_o);
endmodule

// File: tb/ctl_mode_sel_tb.sv
module ctl_mode_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_par = 1'b0;
  logic [1:0] clksel = 2'b00;
  logic       fmt = 1'b1;
  logic [1:0] dem = 2'b00;
  logic       spd = 1'b0;
  logic [1:0] dem_o, mclk_o;
  logic       spd_o, fmt_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctl_mode_sel u_dut (
    .clk(clk), .rst_n(rst_n), .mode_par_i(mode_par), .clksel_pin_i(clksel),
    .fmt_pin_i(fmt), .dem_pin_i(dem), .speed_pin_i(spd),
    .dem_sel_o(dem_o), .speed_sel_o(spd_o), .fmt_sel_o(fmt_o), .mclk_sel_o(mclk_o)
  );

  // parallel vectors: {dem,spd,clksel,fmt} -> {dem,spd,fmt,mclk}
  localparam logic [11:0] PAR_VEC [6] = '{
    12'b000000_000000,
    12'b010011_010101,
    12'b100100_100010,
    12'b110111_110111,
    12'b101010_011001,
    12'b111001_011100
  };

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {dem_o, spd_o, fmt_o, mclk_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] f, input int nbits);
    fmt = 1'b0; wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      clksel[1] = (i < 16) ? f[15-i] : 1'b0;
      wait_clk(4); clksel[0] = 1'b1;
      wait_clk(4); clksel[0] = 1'b0;
    end
    wait_clk(4); fmt = 1'b1; wait_clk(8);
    clksel = 2'b00;
  endtask

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    chk("R6 reset defaults", 6'b01_0_0_00);

    mode_par = 1'b1;
    for (int i = 0; i < 6; i++) begin
      {dem, spd, clksel, fmt} = PAR_VEC[i][11:6];
      wait_clk(1);
      chk("R1 R4 R5 parallel pins", PAR_VEC[i][5:0]);
    end
    {dem, spd, clksel, fmt} = 6'b000001;
    mode_par = 1'b0; wait_clk(4);

    send(16'h3002, 16);
    chk("R7 R4 write dem 48k", 6'b10_0_0_00);
    send(16'h3003, 15);
    chk("R8 short frame", 6'b10_0_0_00);
    send(16'h3003, 17);
    chk("R8 long frame", 6'b10_0_0_00);
    send(16'h2003, 16);
    chk("R9 write flag 0", 6'b10_0_0_00);
    send(16'hB003, 16);
    chk("R9 unmapped address", 6'b10_0_0_00);
    send(16'h1007, 16);
    chk("R2 format and ratio from register", 6'b10_0_1_11);

    dem = 2'b01; wait_clk(1);
    chk("R3 dem pin OR register", 6'b11_0_1_11);
    spd = 1'b1; wait_clk(1);
    chk("R3 R5 speed pin forces off", 6'b01_1_1_11);
    dem = 2'b00; spd = 1'b0; wait_clk(1);
    send(16'h3006, 16);
    chk("R5 register speed forces off", 6'b01_1_1_11);

    mode_par = 1'b1; wait_clk(2);
    send(16'h3000, 16);
    send(16'h1000, 16);
    mode_par = 1'b0; wait_clk(4);
    chk("R10 parallel mode ignores serial", 6'b01_1_1_11);

    rst_n = 1'b0; wait_clk(2); rst_n = 1'b1; wait_clk(2);
    chk("R6 defaults after reset", 6'b01_0_0_00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule